// File: doc/BRIEF.md
# Staggered Linear CCD Drive Timing Generator

This block produces every digital drive signal that a three-colour, quad-staggered linear CCD image sensor needs during scanning. It times one transfer-gate period after another. Each period has a settle window with the resolution-select lines steady, then the transfer-gate pulse, then a frozen interval. After that the two shift-register phases resume while the reset gate and the level clamp are still held, and finally the line is read out pixel by pixel. Every timing limit is given in nanoseconds as a parameter and turned into clock cycles when the block is elaborated.

A two-bit resolution input selects 4800, 2400, 1200 or 600 dpi. The block samples it only at the start of a transfer-gate period. The selected resolution sets the select-line code and the lengths of the readout segments, which are derived from the 2400 dpi lengths. In 4800 dpi mode the select code alternates between the odd and even photocell halves on successive periods.

For a downstream converter the block emits a one-cycle pixel strobe together with a segment tag, and a line-start flag on the first dark-reference pixel. The strobe is a valid-only stream with no ready input. The sensor's charge transfer cannot stall, so a consumer must accept every strobe in the cycle it appears.

Top module: `ccd_line_timer`

## Requirements
- R1: The select code {res_sel[2],res_sel[1],res_sel[0]} is 3'b010 for 2400 dpi (res_mode=1) and 3'b000 for 1200 dpi (res_mode=2) and 600 dpi (res_mode=3). It does not change while xfer_gate is high.
- R2: In 4800 dpi mode (res_mode=0), res_sel[1:0] is 2'b11 and res_sel[2] gives the half being read: 0 for odd, 1 for even. The half toggles on every period, and the first period after entering the mode from another mode reads the odd half.
- R3: Each line's strobes carry tags in this order: a dark-reference run, a leading invalid run, the active run and a trailing invalid run. At 2400 and 4800 dpi the run lengths are the base lengths. At 1200 dpi they are the base lengths divided by 2, and at 600 dpi divided by 4.
- R4: From the start of a period until the shift phases resume, phi1 is 1, phi2 is 0, and reset_gate and clamp are 1. In particular this holds during the whole xfer_gate pulse.
- R5: xfer_gate is high for ceil(XFER_NS/CLK_PERIOD_NS) cycles. The select code is steady for at least ceil(SETUP_NS/CLK_PERIOD_NS) cycles before the pulse. phi1 first falls ceil(SETTLE_NS/CLK_PERIOD_NS)+SHIFT_NS/(2*CLK_PERIOD_NS) cycles after the pulse ends.
- R6: After the phases resume, reset_gate and clamp stay high for ceil(RELEASE_NS/SHIFT_NS) whole shift cycles. Only then does readout begin.
- R7: phi2 is always the complement of phi1. One shift cycle lasts SHIFT_NS/CLK_PERIOD_NS clocks, with each level held for half of it.
- R8: pix_strobe is a single-cycle pulse, one per pixel. It comes every shift cycle, or every second shift cycle at 600 dpi, where two pixels merge. During readout, reset_gate and clamp are high only in strobe cycles.
- R9: A change of res_mode takes effect only at the start of the next transfer-gate period. The line being read keeps its old select code and lengths.
- R10: line_start is high only together with the strobe of the first dark-reference pixel of a line.
- R11: pix_tag is 2'b01 for dark reference, 2'b10 for invalid and 2'b11 for active while pix_strobe is high, and 2'b00 otherwise.
- R12: While rst_n is low, xfer_gate=0, phi1=1, phi2=0, reset_gate=1, clamp=1, res_sel=3'b000, pix_strobe=0, pix_tag=2'b00 and line_start=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_mode | input | 2 | Resolution: 0=4800, 1=2400, 2=1200, 3=600 dpi |
| xfer_gate | output | 1 | Transfer-gate pulse, common to all three colours |
| phi1 | output | 1 | Shift-register phase 1 |
| phi2 | output | 1 | Shift-register phase 2, complement of phi1 |
| reset_gate | output | 1 | Output-node reset gate |
| clamp | output | 1 | Reset-level clamp pulse |
| res_sel | output | 3 | Resolution-select lines |
| pix_strobe | output | 1 | One-cycle pixel-valid strobe (no back-pressure) |
| pix_tag | output | 2 | Segment tag of the strobed pixel |
| line_start | output | 1 | First dark-reference pixel of a line |

## Verification
Several properties are checked on every cycle: the phases stay parked with reset and clamp held during the transfer pulse, the select code stays steady across the pulse, the pulse width is exact, strobes are never adjacent, and line_start coincides with a dark-reference strobe. Checks also confirm that the latched mode and the odd/even half change only at a period boundary. Only the directed scenarios can show the things that depend on whole lines: the order and length of the segments per mode, the strobe spacing at 600 dpi, and the odd/even alternation with its reset to odd on re-entry. The same applies to the exact delays from the pulse to phase resumption and readout, and to a mode change made during readout reaching only the following line.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef enum logic [1:0] {
    RES_4800 = 2'd0,
    RES_2400 = 2'd1,
    RES_1200 = 2'd2,
    RES_600  = 2'd3
  } res_mode_e;

  typedef enum logic [1:0] {
    TAG_IDLE    = 2'd0,
    TAG_DARK    = 2'd1,
    TAG_INVALID = 2'd2,
    TAG_ACTIVE  = 2'd3
  } pix_tag_e;

  typedef enum logic [1:0] {
    SEG_DARK, SEG_LEAD, SEG_BODY, SEG_TRAIL
  } seg_e;

  typedef enum logic [2:0] {
    PH_LATCH, PH_SETUP, PH_XFER, PH_SETTLE, PH_RELEASE, PH_READ
  } period_e;
endpackage

// File: rtl/ccd_shift_gen.sv
module ccd_shift_gen #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phi_a,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phi_a <= 1'b1;
    end else if (!run) begin
      cnt_q <= '0;
      phi_a <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      phi_a <= ~phi_a;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a shift cycle completes when the low half ends
  assign tick = run && (cnt_q == LAST) && !phi_a;

  AST_PHASE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phi_a); // R4
endmodule

// File: rtl/ccd_period_seq.sv
module ccd_period_seq
  import ccd_tg_pkg::*;
#(
  parameter int SETUP_CYC  = 100,
  parameter int XFER_CYC   = 1500,
  parameter int SETTLE_CYC = 700,
  parameter int REL_SHIFTS = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode_in,
  input  logic      tick,
  input  logic      read_done,
  output res_mode_e mode_q,
  output logic      even_q,
  output logic      xfer,
  output logic      hold,
  output logic      run,
  output logic      reading
);
  localparam int M_A  = (SETUP_CYC > XFER_CYC) ? SETUP_CYC : XFER_CYC;
  localparam int M_B  = (SETTLE_CYC > REL_SHIFTS) ? SETTLE_CYC : REL_SHIFTS;
  localparam int MAXT = (M_A > M_B) ? M_A : M_B;
  localparam int CW   = $clog2(MAXT + 1);

  period_e       period_q;
  logic [CW-1:0] cnt_q;
  res_mode_e     mode_next;

  function automatic logic at_end(input logic [CW-1:0] c, input int lim);
    return c == CW'(lim - 1);
  endfunction

  assign mode_next = res_mode_e'(mode_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PH_LATCH;
      cnt_q    <= '0;
      mode_q   <= RES_600;
      even_q   <= 1'b0;
    end else begin
      case (period_q)
        PH_LATCH: begin
          mode_q   <= mode_next;
          even_q   <= (mode_next == RES_4800 && mode_q == RES_4800) ? ~even_q : 1'b0;
          cnt_q    <= '0;
          period_q <= PH_SETUP;
        end
        PH_SETUP:
          if (at_end(cnt_q, SETUP_CYC)) begin
            cnt_q <= '0; period_q <= PH_XFER;
          end else cnt_q <= cnt_q + 1'b1;
        PH_XFER:
          if (at_end(cnt_q, XFER_CYC)) begin
            cnt_q <= '0; period_q <= PH_SETTLE;
          end else cnt_q <= cnt_q + 1'b1;
        PH_SETTLE:
          if (at_end(cnt_q, SETTLE_CYC)) begin
            cnt_q <= '0; period_q <= PH_RELEASE;
          end else cnt_q <= cnt_q + 1'b1;
        PH_RELEASE:
          if (tick) begin
            if (at_end(cnt_q, REL_SHIFTS)) begin
              cnt_q <= '0; period_q <= PH_READ;
            end else cnt_q <= cnt_q + 1'b1;
          end
        PH_READ:
          if (read_done) period_q <= PH_LATCH;
        default: period_q <= PH_LATCH;
      endcase
    end
  end

  assign xfer    = (period_q == PH_XFER);
  assign reading = (period_q == PH_READ);
  assign hold    = !reading;
  assign run     = (period_q == PH_RELEASE) || reading;

  // checker: width of the transfer pulse
  logic [CW-1:0] xrun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xrun_q <= '0;
    else        xrun_q <= xfer ? xrun_q + 1'b1 : '0;
  end

  AST_XFER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer) |-> xrun_q == CW'(XFER_CYC)); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q != PH_LATCH) |=> $stable(mode_q)); // R9
  AST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q != PH_LATCH) |=> $stable(even_q)); // R2
endmodule

// File: rtl/ccd_pixel_seg.sv
module ccd_pixel_seg
  import ccd_tg_pkg::*;
#(
  parameter int OB_PIX    = 96,
  parameter int LEAD_PIX  = 8,
  parameter int ACT_PIX   = 21360,
  parameter int TRAIL_PIX = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  res_mode_e mode,
  input  logic      tick,
  output logic      done,
  output logic      strobe_q,
  output pix_tag_e  tag_q,
  output logic      ls_q
);
  localparam int M_A  = (OB_PIX > LEAD_PIX) ? OB_PIX : LEAD_PIX;
  localparam int M_B  = (ACT_PIX > TRAIL_PIX) ? ACT_PIX : TRAIL_PIX;
  localparam int MAXP = (M_A > M_B) ? M_A : M_B;
  localparam int PW   = $clog2(MAXP + 1);

  seg_e          seg_q;
  logic [PW-1:0] pcnt_q;
  logic          sub_q;
  logic [1:0]    sh;
  logic [PW-1:0] seg_len;
  pix_tag_e      seg_tag;
  logic          pix_end, last_in_seg;

  always_comb begin
    case (mode)
      RES_1200: sh = 2'd1;
      RES_600:  sh = 2'd2;
      default:  sh = 2'd0;
    endcase
  end

  always_comb begin
    case (seg_q)
      SEG_DARK:  begin seg_len = PW'(OB_PIX)    >> sh; seg_tag = TAG_DARK;    end
      SEG_LEAD:  begin seg_len = PW'(LEAD_PIX)  >> sh; seg_tag = TAG_INVALID; end
      SEG_BODY:  begin seg_len = PW'(ACT_PIX)   >> sh; seg_tag = TAG_ACTIVE;  end
      default:   begin seg_len = PW'(TRAIL_PIX) >> sh; seg_tag = TAG_INVALID; end
    endcase
  end

  // at 600 dpi two shift cycles merge into one pixel
  assign pix_end     = active && tick && ((mode != RES_600) || sub_q);
  assign last_in_seg = (pcnt_q == seg_len - 1'b1);
  assign done        = pix_end && last_in_seg && (seg_q == SEG_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_DARK;
      pcnt_q   <= '0;
      sub_q    <= 1'b0;
      strobe_q <= 1'b0;
      tag_q    <= TAG_IDLE;
      ls_q     <= 1'b0;
    end else begin
      strobe_q <= pix_end;
      tag_q    <= pix_end ? seg_tag : TAG_IDLE;
      ls_q     <= pix_end && (seg_q == SEG_DARK) && (pcnt_q == '0);
      if (!active) begin
        seg_q  <= SEG_DARK;
        pcnt_q <= '0;
        sub_q  <= 1'b0;
      end else if (tick) begin
        if (mode == RES_600) sub_q <= ~sub_q;
        if (pix_end) begin
          if (last_in_seg) begin
            pcnt_q <= '0;
            seg_q  <= (seg_q == SEG_TRAIL) ? SEG_DARK : seg_e'(seg_q + 2'd1);
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
      end
    end
  end

  AST_LINE_START_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    ls_q |-> (strobe_q && tag_q == TAG_DARK)); // R10
  AST_TAG_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |-> (tag_q == TAG_IDLE)); // R11
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_tg_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SHIFT_NS      = 100,
  parameter int SETUP_NS      = 1000,
  parameter int XFER_NS       = 15000,
  parameter int SETTLE_NS     = 7000,
  parameter int RELEASE_NS    = 500,
  parameter int OB_PIX        = 96,
  parameter int LEAD_PIX      = 8,
  parameter int ACT_PIX       = 21360,
  parameter int TRAIL_PIX     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] res_mode,
  output logic       xfer_gate,
  output logic       phi1,
  output logic       phi2,
  output logic       reset_gate,
  output logic       clamp,
  output logic [2:0] res_sel,
  output logic       pix_strobe,
  output logic [1:0] pix_tag,
  output logic       line_start
);
  localparam int HALF_CYC   = SHIFT_NS / (2 * CLK_PERIOD_NS);
  localparam int SETUP_CYC  = (SETUP_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int XFER_CYC   = (XFER_NS   + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int SETTLE_CYC = (SETTLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int REL_SHIFTS = (RELEASE_NS + SHIFT_NS - 1) / SHIFT_NS;

  res_mode_e mode_q;
  logic      even_q, hold, run, reading, tick, done, strobe, ls;
  pix_tag_e  tag;

  ccd_shift_gen #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .phi_a(phi1), .tick(tick)
  );

  ccd_period_seq #(
    .SETUP_CYC(SETUP_CYC), .XFER_CYC(XFER_CYC),
    .SETTLE_CYC(SETTLE_CYC), .REL_SHIFTS(REL_SHIFTS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_in(res_mode), .tick(tick),
    .read_done(done), .mode_q(mode_q), .even_q(even_q), .xfer(xfer_gate),
    .hold(hold), .run(run), .reading(reading)
  );

  ccd_pixel_seg #(
    .OB_PIX(OB_PIX), .LEAD_PIX(LEAD_PIX), .ACT_PIX(ACT_PIX), .TRAIL_PIX(TRAIL_PIX)
  ) u_seg (
    .clk(clk), .rst_n(rst_n), .active(reading), .mode(mode_q), .tick(tick),
    .done(done), .strobe_q(strobe), .tag_q(tag), .ls_q(ls)
  );

  always_comb begin
    case (mode_q)
      RES_4800: res_sel = {even_q, 2'b11};
      RES_2400: res_sel = 3'b010;
      default:  res_sel = 3'b000;
    endcase
  end

  assign phi2       = ~phi1;
  assign reset_gate = hold | strobe;
  assign clamp      = hold | strobe;
  assign pix_strobe = strobe;
  assign pix_tag    = tag;
  assign line_start = ls;

  AST_XFER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> (phi1 && reset_gate && clamp)); // R4
  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> $stable(res_sel)); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |=> !pix_strobe); // R8
endmodule

// File: tb/tb_ccd_line_timer.sv
module tb_ccd_line_timer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 2;   // SHIFT_NS 40
  localparam int T_SET  = 3;   // SETUP_NS 30
  localparam int T_XFER = 6;   // XFER_NS 60
  localparam int T_SETL = 5;   // SETTLE_NS 50
  localparam int N_REL  = 2;   // RELEASE_NS 80
  localparam int B_OB = 8, B_LEAD = 4, B_ACT = 16, B_TRAIL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] res_mode = 2'd1;
  logic xfer_gate, phi1, phi2, reset_gate, clamp, pix_strobe, line_start;
  logic [2:0] res_sel;
  logic [1:0] pix_tag;

  int checks = 0, fails = 0;
  int sel_run = 0;
  logic [2:0] sel_prev = 3'b000;

  ccd_line_timer #(
    .CLK_PERIOD_NS(CLK_PERIOD), .SHIFT_NS(40), .SETUP_NS(30), .XFER_NS(60),
    .SETTLE_NS(50), .RELEASE_NS(80), .OB_PIX(B_OB), .LEAD_PIX(B_LEAD),
    .ACT_PIX(B_ACT), .TRAIL_PIX(B_TRAIL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .res_mode(res_mode), .xfer_gate(xfer_gate),
    .phi1(phi1), .phi2(phi2), .reset_gate(reset_gate), .clamp(clamp),
    .res_sel(res_sel), .pix_strobe(pix_strobe), .pix_tag(pix_tag),
    .line_start(line_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // every sample goes through here, away from the rising edge
  task automatic step();
    @(negedge clk);
    if (res_sel == sel_prev) sel_run++; else sel_run = 1;
    sel_prev = res_sel;
  endtask

  function automatic int exp_tag(input int i, input int sh);
    int ob = B_OB >> sh, ld = B_LEAD >> sh, ac = B_ACT >> sh;
    if (i < ob) return 1;
    if (i < ob + ld) return 2;
    if (i < ob + ld + ac) return 3;
    return 2;
  endfunction

  // capture one transfer period and its readout; drive next_mode mid-readout
  task automatic check_line(input string name, input logic [1:0] cur,
                            input logic [2:0] exp_sel, input string sel_req,
                            input string len_req, input logic [1:0] next_mode);
    int sh, tgw, post, rel, n, tag_err, ls_err, gap_err, rb_err, frz_err;
    int gap, quiet, setup_seen, total, exp_gap;
    logic [2:0] sel_at;
    sh = (cur == 2'd2) ? 1 : (cur == 2'd3) ? 2 : 0;
    total = (B_OB + B_LEAD + B_ACT + B_TRAIL) >> sh;
    exp_gap = 2 * HALF * ((cur == 2'd3) ? 2 : 1);
    tgw = 0; post = 0; rel = 0; n = 0; tag_err = 0; ls_err = 0;
    gap_err = 0; rb_err = 0; frz_err = 0; gap = 0; quiet = 0;
    do step(); while (!xfer_gate);
    sel_at = res_sel;
    setup_seen = sel_run - 1;
    while (xfer_gate) begin
      tgw++;
      if (!phi1 || phi2 || !reset_gate || !clamp) frz_err++;
      step();
    end
    while (phi1) begin
      post++;
      if (!reset_gate || !clamp || phi2) frz_err++;
      step();
    end
    while (reset_gate) begin
      rel++;
      if (phi2 == phi1) frz_err++;
      step();
    end
    forever begin
      if (phi2 == phi1) frz_err++;
      if (pix_strobe) begin
        if (int'(pix_tag) != exp_tag(n, sh)) tag_err++;
        if (line_start != (n == 0)) ls_err++;
        if (n > 0 && gap != exp_gap) gap_err++;
        if (!reset_gate || !clamp) rb_err++;
        n++;
        gap = 0;
        quiet = 0;
        if (n == 2) res_mode = next_mode;
      end else begin
        if (pix_tag != 2'b00 || line_start) tag_err++;
        if (reset_gate != clamp) rb_err++;
        if (reset_gate) quiet++; else quiet = 0;
        if (quiet >= 2) break;
      end
      gap++;
      step();
    end
    check(sel_at == exp_sel, sel_req, {name, " select code"}, sel_at, exp_sel);
    check(setup_seen >= T_SET, "R5", {name, " select settle"}, setup_seen, T_SET);
    check(tgw == T_XFER, "R5", {name, " transfer width"}, tgw, T_XFER);
    check(post == T_SETL + HALF, "R5", {name, " phase resume delay"}, post, T_SETL + HALF);
    check(rel == N_REL * 2 * HALF - HALF, "R6", {name, " release window"}, rel, N_REL * 2 * HALF - HALF);
    check(frz_err == 0, "R4", {name, " frozen/complement violations"}, frz_err, 0);
    check(n == total, len_req, {name, " strobe count"}, n, total);
    check(tag_err == 0, "R3", {name, " tag order errors (R11)"}, tag_err, 0);
    check(ls_err == 0, "R10", {name, " line_start errors"}, ls_err, 0);
    check(gap_err == 0, "R8", {name, " strobe spacing errors (R7)"}, gap_err, 0);
    check(rb_err == 0, "R8", {name, " reset/clamp pulse errors"}, rb_err, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check(xfer_gate == 1'b0, "R12", "reset xfer_gate", xfer_gate, 0);
    check(phi1 == 1'b1 && phi2 == 1'b0, "R12", "reset phases", {phi1, phi2}, 2);
    check(reset_gate && clamp, "R12", "reset gate/clamp", {reset_gate, clamp}, 3);
    check(res_sel == 3'b000, "R12", "reset select", res_sel, 0);
    check(!pix_strobe && pix_tag == 2'b00 && !line_start, "R12", "reset stream",
          {pix_strobe, pix_tag, line_start}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_res2400();
    check_line("2400a", 2'd1, 3'b010, "R1", "R3", 2'd1);
    check_line("2400b", 2'd1, 3'b010, "R1", "R9", 2'd2); // R9: switch mid-line
  endtask

  task automatic t_res1200();
    check_line("1200", 2'd2, 3'b000, "R1", "R9", 2'd3);
  endtask

  task automatic t_res600();
    check_line("600a", 2'd3, 3'b000, "R1", "R3", 2'd3);
    check_line("600b", 2'd3, 3'b000, "R1", "R9", 2'd0);
  endtask

  task automatic t_res4800();
    check_line("4800 odd",  2'd0, 3'b011, "R2", "R3", 2'd0);
    check_line("4800 even", 2'd0, 3'b111, "R2", "R3", 2'd0);
    check_line("4800 odd2", 2'd0, 3'b011, "R2", "R9", 2'd1);
  endtask

  task automatic t_reenter4800();
    check_line("2400 gap", 2'd1, 3'b010, "R1", "R9", 2'd0);
    check_line("4800 reentry odd", 2'd0, 3'b011, "R2", "R3", 2'd0);
  endtask

  initial begin
    t_reset();
    t_res2400();
    t_res1200();
    t_res600();
    t_res4800();
    t_reenter4800();
    summary();
    $finish;
  end
endmodule